// File: doc/BRIEF.md
# Floating-Point Control and Status Register with Rounding-Mode Resolution

This block stores the floating-point control and status word of a scalar core. The word has two fields. A 3-bit rounding-mode field sits at bits 7:5. Five sticky exception flags sit at bits 4:0. Software replaces the whole word with a single write and can read it back at any time. Every bit above bit 7 reads as zero.

In any cycle the floating-point datapath can present a pulse of exception flags. The block ORs that pulse into the stored flags. A flag that has been set stays set until software writes over it.

Each floating-point instruction carries its own 3-bit rounding field, and the block turns it into the mode actually used. A field value of 7 means "dynamic": the block substitutes the mode held in the register. Any other value is used as given. If the resulting mode is above 4, the block raises an illegal-instruction flag, but only while the instruction-valid input is high. This resolution is combinational and always uses the register contents from before the current clock edge. Delivering the trap is left to the core.

Top module: `fp_status_csr`

## Requirements
- R1: A synchronous active-high reset clears the whole register, so the read port shows 0 in the cycle after reset.
- R2: A write loads bits 7:5 of the write data into the rounding-mode field and bits 4:0 into the flags. The read port shows the new value one cycle later.
- R3: Read bits above bit 7 are always zero, whatever was written to those positions.
- R4: When the flag-pulse valid input is high, each set bit of the pulse becomes set in the stored flags one cycle later. The flag encoding is: inexact bit0, underflow bit1, overflow bit2, divide-by-zero bit3, invalid bit4.
- R5: Without a write, no stored flag ever clears. Pulse bits presented while the pulse valid input is low have no effect.
- R6: When a write and a valid flag pulse occur in the same cycle, the flags become the written flag bits ORed with the pulse.
- R7: Instruction rounding values 0 to 4 pass through unchanged as the effective mode, with no illegal flag. The codes are: 0 nearest-even, 1 toward zero, 2 down, 3 up, 4 nearest with ties to max magnitude.
- R8: An instruction rounding value of 7 makes the effective mode equal to the stored rounding-mode field.
- R9: While instruction-valid is high, an effective mode above 4 raises the illegal flag. This covers static values 5 and 6 as well as a dynamic selection of a stored value from 5 to 7.
- R10: While instruction-valid is low, the illegal flag stays low.
- R11: A flag pulse without a write leaves the rounding-mode field unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr_en | input | 1 | Full-word write strobe |
| csr_wr_data | input | XLEN | Write data; only bits 7:0 are stored |
| csr_rd_data | output | XLEN | Current register value, zero-extended |
| exc_valid | input | 1 | Flag pulse from the datapath is valid |
| exc_flags | input | 5 | Exception flags to accumulate |
| insn_valid | input | 1 | A floating-point instruction is being resolved |
| insn_rm | input | 3 | Rounding field carried by the instruction |
| eff_rm | output | 3 | Resolved effective rounding mode |
| rm_illegal | output | 1 | Effective mode unsupported, qualified by insn_valid |

## Verification
Two functions can act in the same cycle: a software write and a flag pulse from the datapath. The bench drives both in one cycle and expects the read-back value to hold the written flags ORed with the pulse.

A second overlap occurs when a write changes the rounding mode in the same cycle that a dynamic instruction resolves. The bench expects the resolution to use the old mode in that cycle and the new mode in the next cycle. A scoreboard model predicts both the read port and the resolver outputs for every cycle.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;
  localparam int FLAG_W = 5;
  localparam int RM_W   = 3;

  localparam logic [RM_W-1:0] RM_DYN       = 3'd7;
  localparam logic [RM_W-1:0] RM_MAX_LEGAL = 3'd4;

  typedef enum logic [RM_W-1:0] {
    RM_NEAR_EVEN = 3'd0,
    RM_TO_ZERO   = 3'd1,
    RM_DOWN      = 3'd2,
    RM_UP        = 3'd3,
    RM_NEAR_MAX  = 3'd4
  } rmode_e;

  localparam int FL_INEXACT  = 0;
  localparam int FL_UNDER    = 1;
  localparam int FL_OVER     = 2;
  localparam int FL_DIVZERO  = 3;
  localparam int FL_INVALID  = 4;
endpackage

// File: rtl/fpcsr_flags.sv
module fpcsr_flags
  import fpcsr_pkg::*;
#(
  parameter int FW = FLAG_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [FW-1:0] wr_flags,
  input  logic          acc_en,
  input  logic [FW-1:0] acc_flags,
  output logic [FW-1:0] flags_q
);
  logic [FW-1:0] acc_masked;
  logic [FW-1:0] flags_d;

  assign acc_masked = acc_en ? acc_flags : '0;

  always_comb begin
    if (wr_en) flags_d = wr_flags | acc_masked;
    else       flags_d = flags_q | acc_masked;
  end

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= flags_d;
  end

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ((flags_q & $past(flags_q)) == $past(flags_q))); // R5

  AST_FLAGS_ACCUM: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && acc_en) |=> ((flags_q & $past(acc_flags)) == $past(acc_flags))); // R4

  AST_FLAGS_LOAD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !acc_en) |=> (flags_q == $past(wr_flags))); // R2
endmodule

// File: rtl/fpcsr_rmreg.sv
module fpcsr_rmreg
  import fpcsr_pkg::*;
#(
  parameter int RW = RM_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [RW-1:0] wr_rm,
  output logic [RW-1:0] rm_q
);
  always_ff @(posedge clk) begin
    if (rst)        rm_q <= '0;
    else if (wr_en) rm_q <= wr_rm;
  end

  AST_RM_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(rm_q)); // R11
endmodule

// File: rtl/fpcsr_rm_resolve.sv
module fpcsr_rm_resolve
  import fpcsr_pkg::*;
#(
  parameter int RW = RM_W
) (
  input  logic          insn_valid,
  input  logic [RW-1:0] insn_rm,
  input  logic [RW-1:0] dyn_rm,
  output logic [RW-1:0] eff_rm,
  output logic          illegal
);
  logic use_dyn;
  logic over_max;

  assign use_dyn  = (insn_rm == RW'(RM_DYN));
  assign eff_rm   = use_dyn ? dyn_rm : insn_rm;
  assign over_max = (eff_rm > RW'(RM_MAX_LEGAL));
  assign illegal  = insn_valid & over_max;
endmodule

// File: rtl/fp_status_csr.sv
module fp_status_csr
  import fpcsr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csr_wr_en,
  input  logic [XLEN-1:0]   csr_wr_data,
  output logic [XLEN-1:0]   csr_rd_data,
  input  logic              exc_valid,
  input  logic [FLAG_W-1:0] exc_flags,
  input  logic              insn_valid,
  input  logic [RM_W-1:0]   insn_rm,
  output logic [RM_W-1:0]   eff_rm,
  output logic              rm_illegal
);
  localparam int RM_LSB = FLAG_W;
  localparam int RM_MSB = RM_LSB + RM_W - 1;
  localparam int PAD_W  = XLEN - RM_MSB - 1;

  logic [FLAG_W-1:0] flags_q;
  logic [RM_W-1:0]   rm_q;
  logic              unused_wr_hi;

  assign unused_wr_hi = ^csr_wr_data[XLEN-1:RM_MSB+1];

  fpcsr_flags #(.FW(FLAG_W)) u_flags (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (csr_wr_en),
    .wr_flags  (csr_wr_data[FLAG_W-1:0]),
    .acc_en    (exc_valid),
    .acc_flags (exc_flags),
    .flags_q   (flags_q)
  );

  fpcsr_rmreg #(.RW(RM_W)) u_rm (
    .clk   (clk),
    .rst   (rst),
    .wr_en (csr_wr_en),
    .wr_rm (csr_wr_data[RM_MSB:RM_LSB]),
    .rm_q  (rm_q)
  );

  fpcsr_rm_resolve #(.RW(RM_W)) u_resolve (
    .insn_valid (insn_valid),
    .insn_rm    (insn_rm),
    .dyn_rm     (rm_q),
    .eff_rm     (eff_rm),
    .illegal    (rm_illegal)
  );

  assign csr_rd_data = {{PAD_W{1'b0}}, rm_q, flags_q};

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (csr_rd_data == '0)); // R1

  AST_DYN_SELECT: assert property (@(posedge clk) disable iff (rst)
    (insn_valid && insn_rm == RM_DYN) |-> (eff_rm == csr_rd_data[RM_MSB:RM_LSB])); // R8

  AST_ILLEGAL_RANGE: assert property (@(posedge clk) disable iff (rst)
    rm_illegal |-> (insn_valid && eff_rm > RM_MAX_LEGAL)); // R9

  AST_ILLEGAL_QUAL: assert property (@(posedge clk) disable iff (rst)
    !insn_valid |-> !rm_illegal); // R10
endmodule

// File: tb/fp_status_csr_tb.sv
module fp_status_csr_tb;
  localparam int XLEN = 32;

  typedef struct {
    logic [XLEN-1:0] rd;
    logic [2:0]      eff;
    logic            ill;
    string           tag;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            csr_wr_en = 1'b0;
  logic [XLEN-1:0] csr_wr_data = '0;
  logic [XLEN-1:0] csr_rd_data;
  logic            exc_valid = 1'b0;
  logic [4:0]      exc_flags = '0;
  logic            insn_valid = 1'b0;
  logic [2:0]      insn_rm = '0;
  logic [2:0]      eff_rm;
  logic            rm_illegal;

  int   total = 0;
  int   bad = 0;
  bit   done = 0;
  exp_t q[$];

  logic [2:0] m_rm = '0;
  logic [4:0] m_fl = '0;

  always #10 clk = ~clk;

  fp_status_csr #(.XLEN(XLEN)) u_dut (
    .clk(clk), .rst(rst), .csr_wr_en(csr_wr_en), .csr_wr_data(csr_wr_data),
    .csr_rd_data(csr_rd_data), .exc_valid(exc_valid), .exc_flags(exc_flags),
    .insn_valid(insn_valid), .insn_rm(insn_rm), .eff_rm(eff_rm),
    .rm_illegal(rm_illegal)
  );

  // Driver: at a falling edge, apply inputs, push the expected outputs, update the model
  task automatic step(input logic wr, input logic [XLEN-1:0] wd, input logic fv,
                      input logic [4:0] fb, input logic iv, input logic [2:0] irm,
                      input string tag);
    exp_t e;
    logic [2:0] ef;
    @(negedge clk);
    csr_wr_en = wr; csr_wr_data = wd; exc_valid = fv; exc_flags = fb;
    insn_valid = iv; insn_rm = irm;
    ef = (irm == 3'd7) ? m_rm : irm;
    e.rd = {{(XLEN-8){1'b0}}, m_rm, m_fl};
    e.eff = ef;
    e.ill = iv && (ef > 3'd4);
    e.tag = tag;
    q.push_back(e);
    if (wr) begin
      m_rm = wd[7:5];
      m_fl = wd[4:0] | (fv ? fb : 5'd0);
    end else if (fv) begin
      m_fl = m_fl | fb;
    end
  endtask

  task automatic idle(input string tag);
    step(1'b0, '0, 1'b0, 5'd0, 1'b0, 3'd0, tag);
  endtask

  // Monitor: pop and compare, away from the rising edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        total++;
        if (csr_rd_data !== e.rd || eff_rm !== e.eff || rm_illegal !== e.ill) begin
          bad++;
          $display("FAIL %s: rd=%h eff=%0d ill=%0b expected rd=%h eff=%0d ill=%0b",
                   e.tag, csr_rd_data, eff_rm, rm_illegal, e.rd, e.eff, e.ill);
        end
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    idle("R1 reset state");
    // R2 R3: write with junk upper bits, rm=3 flags=0x0A
    step(1'b1, 32'hFFFF_FF6A, 1'b0, 5'd0, 1'b0, 3'd0, "R2 write");
    idle("R3 upper bits zero");
    // R4: accumulate invalid, then inexact
    step(1'b0, '0, 1'b1, 5'h10, 1'b0, 3'd0, "R4 pulse");
    step(1'b0, '0, 1'b1, 5'h01, 1'b0, 3'd0, "R4 pulse");
    // R5: pulse bits without valid have no effect
    step(1'b0, '0, 1'b0, 5'h1F, 1'b0, 3'd0, "R5 invalid pulse ignored");
    idle("R5 sticky");
    // R6: write zero together with an overflow pulse
    step(1'b1, 32'h0000_0000, 1'b1, 5'h04, 1'b0, 3'd0, "R6 write+pulse");
    idle("R6 merged result");
    // R7: static modes
    for (int k = 0; k < 5; k++) step(1'b0, '0, 1'b0, 5'd0, 1'b1, 3'(k), "R7 static pass");
    // R9: static 5 and 6
    step(1'b0, '0, 1'b0, 5'd0, 1'b1, 3'd5, "R9 static 5");
    step(1'b0, '0, 1'b0, 5'd0, 1'b1, 3'd6, "R9 static 6");
    // R10: unqualified
    step(1'b0, '0, 1'b0, 5'd0, 1'b0, 3'd6, "R10 no valid");
    step(1'b0, '0, 1'b0, 5'd0, 1'b0, 3'd7, "R10 no valid");
    // R8: write rm=2 while resolving dynamic (old mode this cycle)
    step(1'b1, 32'h0000_0040, 1'b0, 5'd0, 1'b1, 3'd7, "R8 dynamic old");
    step(1'b0, '0, 1'b0, 5'd0, 1'b1, 3'd7, "R8 dynamic new");
    // R11: pulse does not disturb rm=4
    step(1'b1, 32'h0000_0080, 1'b0, 5'd0, 1'b0, 3'd0, "R8 write");
    step(1'b0, '0, 1'b1, 5'h08, 1'b1, 3'd7, "R8 dynamic 4");
    step(1'b0, '0, 1'b1, 5'h02, 1'b1, 3'd7, "R11 rm held");
    // R9: stored 5 and 7 under dynamic
    step(1'b1, 32'h0000_00A0, 1'b0, 5'd0, 1'b0, 3'd0, "R11 rm held");
    step(1'b0, '0, 1'b0, 5'd0, 1'b1, 3'd7, "R9 dynamic 5");
    step(1'b1, 32'h0000_00E3, 1'b1, 5'h10, 1'b0, 3'd7, "R9 write 7");
    step(1'b0, '0, 1'b0, 5'd0, 1'b1, 3'd7, "R9 dynamic 7");
    step(1'b0, '0, 1'b0, 5'd0, 1'b0, 3'd7, "R10 dynamic 7 no valid");
    // R1: reset in mid-run
    @(negedge clk); rst = 1'b1;
    csr_wr_en = 1'b0; exc_valid = 1'b0; insn_valid = 1'b0;
    m_rm = '0; m_fl = '0;
    @(negedge clk); rst = 1'b0;
    idle("R1 reset clears");
    step(1'b0, '0, 1'b0, 5'd0, 1'b1, 3'd7, "R1 dynamic after reset");
    idle("R1 final");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule